// File: doc/BRIEF.md
# Split Direction and Target Branch Predictor

This block sits beside the instruction fetch stage and guesses, in the cycle a fetch address is presented, whether that address holds a taken branch and where fetch should go next. Direction comes from a large, untagged table of 2-bit saturating counters selected by low fetch-address bits. Different branches that share those bits share a counter. A smaller, direct-mapped target store with address tags holds next-fetch addresses. It is consulted only when the counter says taken. When the store cannot supply an address, fetch falls through to the sequential address.

When a branch resolves later in the pipeline, the resolve port presents its address, actual direction and actual target, together with the direction and target that fetch followed. The counter for that address is stepped toward the outcome. A taken branch installs or overwrites its target entry. A resolve that differs from what fetch followed raises a mispredict flag in the same cycle.

Top module: `dir_tgt_predictor`

## Requirements
- R1: A synchronous active-high reset sets every counter to the weakly not-taken value 01 and invalidates every target entry. After reset, any fetch address gives pred_taken=0, pred_tgt_vld=0 and next_pc=f_pc+4.
- R2: On a valid resolve, the selected counter increments for a taken outcome and decrements for a not-taken outcome. It saturates at 11 and 00. pred_taken is bit 1 of the counter.
- R3: From a strong state (11 or 00), a single opposite outcome leaves the predicted direction unchanged. A second consecutive opposite outcome flips it.
- R4: The counter is selected by f_pc[DIR_IDX_W+1:2] and carries no tag. Two addresses that differ only above bit DIR_IDX_W+1 read and train the same counter.
- R5: The target store is indexed by f_pc[TGT_IDX_W+1:2] and tagged with the bits above the index. pred_tgt_vld is 1 only when pred_taken is 1, the entry is valid and its tag matches. Otherwise pred_tgt_vld is 0.
- R6: Only a valid resolve with rs_taken=1 writes the target store. It writes valid, tag and rs_target at the index of rs_pc and replaces whatever entry was resident there. Not-taken resolves leave the store unchanged.
- R7: next_pc equals pred_tgt when pred_tgt_vld is 1. Otherwise it equals f_pc+4.
- R8: When a resolve writes an entry that the current fetch also reads, the fetch outputs in that cycle reflect the contents before the write.
- R9: mispredict is 1 in a cycle where rs_valid=1 and either rs_pred_taken differs from rs_taken, or both are 1 and rs_pred_target differs from rs_target. Otherwise it is 0.
- R10: While rs_valid=0, the resolve inputs change neither table.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| f_pc | input | PC_W | Fetch address being looked up |
| pred_taken | output | 1 | Counter predicts taken |
| pred_tgt_vld | output | 1 | Target store hit on a taken prediction |
| pred_tgt | output | PC_W | Stored target; meaningful when pred_tgt_vld=1 |
| next_pc | output | PC_W | Address to fetch next |
| rs_valid | input | 1 | Resolve information present this cycle |
| rs_pc | input | PC_W | Address of the resolving branch |
| rs_taken | input | 1 | Actual direction |
| rs_target | input | PC_W | Actual target address |
| rs_pred_taken | input | 1 | Direction fetch followed for this branch |
| rs_pred_target | input | PC_W | Target fetch followed when it redirected |
| mispredict | output | 1 | Resolve disagrees with what fetch followed |

## Verification
A corrupted counter appears at pred_taken on the next fetch of any address that maps to it, so the training sequences lookup the trained address directly after each resolve edge. A stale or wrongly tagged target entry appears only while the counter says taken; for this reason, the bench drives the counter strong before it probes eviction and tag aliasing. A write that leaks into the same-cycle lookup, or a not-taken resolve that touches the target store, shows at next_pc one fetch later.

// File: rtl/bp_pkg.sv
package bp_pkg;

    localparam int PC_W = 32;

    typedef logic [1:0] ctr_t;

    localparam ctr_t CTR_STRONG_NT = 2'b00;
    localparam ctr_t CTR_WEAK_NT   = 2'b01;
    localparam ctr_t CTR_STRONG_T  = 2'b11;

    typedef logic [PC_W-1:0] addr_t;

    typedef struct packed {
        logic  taken;
        logic  tgt_vld;
        addr_t tgt;
    } pred_t;

    function automatic ctr_t ctr_step(input ctr_t cur, input logic taken);
        ctr_t nxt;
        if (taken)
            nxt = (cur == CTR_STRONG_T) ? cur : cur + 2'd1;
        else
            nxt = (cur == CTR_STRONG_NT) ? cur : cur - 2'd1;
        return nxt;
    endfunction

    function automatic logic ctr_taken(input ctr_t cur);
        return cur[1];
    endfunction

endpackage

// File: rtl/bp_dir_table.sv
module bp_dir_table
    import bp_pkg::*;
#(
    parameter int IDX_W = 8
) (
    input  logic  clk,
    input  logic  rst,
    input  addr_t lk_pc,
    output logic  lk_taken,
    input  logic  up_en,
    input  addr_t up_pc,
    input  logic  up_taken
);
    localparam int DEPTH = 1 << IDX_W;

    ctr_t cnt_q [DEPTH];

    logic [IDX_W-1:0] lk_idx;
    logic [IDX_W-1:0] up_idx;
    ctr_t             up_cur;

    assign lk_idx   = lk_pc[IDX_W+1:2];
    assign up_idx   = up_pc[IDX_W+1:2];
    assign up_cur   = cnt_q[up_idx];
    assign lk_taken = ctr_taken(cnt_q[lk_idx]);

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) cnt_q[i] <= CTR_WEAK_NT;
        end else if (up_en) begin
            cnt_q[up_idx] <= ctr_step(up_cur, up_taken);
        end
    end

    // R2: a taken outcome raises a non-saturated counter by one
    a_r2_inc_step: assert property (@(posedge clk) disable iff (rst)
        (up_en && up_taken && up_cur != CTR_STRONG_T)
        |=> cnt_q[$past(up_idx)] == $past(up_cur) + 2'd1);

    // R2: a not-taken outcome lowers a non-saturated counter by one
    a_r2_dec_step: assert property (@(posedge clk) disable iff (rst)
        (up_en && !up_taken && up_cur != CTR_STRONG_NT)
        |=> cnt_q[$past(up_idx)] == $past(up_cur) - 2'd1);

    // R3: one not-taken outcome from strongly taken still predicts taken
    a_r3_hyst_t: assert property (@(posedge clk) disable iff (rst)
        (up_en && !up_taken && up_cur == CTR_STRONG_T)
        |=> cnt_q[$past(up_idx)][1]);

    // R3: one taken outcome from strongly not-taken still predicts not-taken
    a_r3_hyst_nt: assert property (@(posedge clk) disable iff (rst)
        (up_en && up_taken && up_cur == CTR_STRONG_NT)
        |=> !cnt_q[$past(up_idx)][1]);

endmodule

// File: rtl/bp_tgt_buffer.sv
module bp_tgt_buffer
    import bp_pkg::*;
#(
    parameter int IDX_W = 4
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  lk_en,
    input  addr_t lk_pc,
    output logic  lk_hit,
    output addr_t lk_tgt,
    input  logic  wr_en,
    input  addr_t wr_pc,
    input  addr_t wr_tgt
);
    localparam int DEPTH = 1 << IDX_W;
    localparam int TAG_W = PC_W - 2 - IDX_W;

    typedef logic [TAG_W-1:0] tag_t;

    logic [DEPTH-1:0] vld_q;
    tag_t             tag_q [DEPTH];
    addr_t            tgt_q [DEPTH];

    logic [IDX_W-1:0] lk_idx;
    logic [IDX_W-1:0] wr_idx;
    tag_t             lk_tag;
    tag_t             wr_tag;

    assign lk_idx = lk_pc[IDX_W+1:2];
    assign lk_tag = lk_pc[PC_W-1:IDX_W+2];
    assign wr_idx = wr_pc[IDX_W+1:2];
    assign wr_tag = wr_pc[PC_W-1:IDX_W+2];

    assign lk_hit = lk_en && vld_q[lk_idx] && (tag_q[lk_idx] == lk_tag);
    assign lk_tgt = tgt_q[lk_idx];

    always_ff @(posedge clk) begin
        if (rst) begin
            vld_q <= '0;
        end else if (wr_en) begin
            vld_q[wr_idx] <= 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (wr_en) begin
            tag_q[wr_idx] <= wr_tag;
            tgt_q[wr_idx] <= wr_tgt;
        end
    end

    // R6: without a taken resolve the valid bits never move
    a_r6_no_fill: assert property (@(posedge clk) disable iff (rst)
        !wr_en |=> $stable(vld_q));

    // R6: a taken resolve leaves its entry valid with the new target
    a_r6_fill: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> vld_q[$past(wr_idx)] && (tgt_q[$past(wr_idx)] == $past(wr_tgt)));

endmodule

// File: rtl/dir_tgt_predictor.sv
module dir_tgt_predictor
    import bp_pkg::*;
#(
    parameter int DIR_IDX_W = 8,
    parameter int TGT_IDX_W = 4
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [PC_W-1:0] f_pc,
    output logic            pred_taken,
    output logic            pred_tgt_vld,
    output logic [PC_W-1:0] pred_tgt,
    output logic [PC_W-1:0] next_pc,
    input  logic            rs_valid,
    input  logic [PC_W-1:0] rs_pc,
    input  logic            rs_taken,
    input  logic [PC_W-1:0] rs_target,
    input  logic            rs_pred_taken,
    input  logic [PC_W-1:0] rs_pred_target,
    output logic            mispredict
);
    localparam addr_t SEQ_STEP = addr_t'(4);

    pred_t pred;
    logic  dir_t_w;
    logic  tgt_hit_w;
    addr_t tgt_w;
    logic  fill_en;

    assign fill_en = rs_valid && rs_taken;

    bp_dir_table #(.IDX_W(DIR_IDX_W)) u_dir (
        .clk      (clk),
        .rst      (rst),
        .lk_pc    (f_pc),
        .lk_taken (dir_t_w),
        .up_en    (rs_valid),
        .up_pc    (rs_pc),
        .up_taken (rs_taken)
    );

    bp_tgt_buffer #(.IDX_W(TGT_IDX_W)) u_tgt (
        .clk    (clk),
        .rst    (rst),
        .lk_en  (dir_t_w),
        .lk_pc  (f_pc),
        .lk_hit (tgt_hit_w),
        .lk_tgt (tgt_w),
        .wr_en  (fill_en),
        .wr_pc  (rs_pc),
        .wr_tgt (rs_target)
    );

    always_comb begin
        pred.taken   = dir_t_w;
        pred.tgt_vld = tgt_hit_w;
        pred.tgt     = tgt_w;
    end

    assign pred_taken   = pred.taken;
    assign pred_tgt_vld = pred.tgt_vld;
    assign pred_tgt     = pred.tgt;
    assign next_pc      = pred.tgt_vld ? pred.tgt : f_pc + SEQ_STEP;

    always_comb begin
        mispredict = 1'b0;
        if (rs_valid) begin
            if (rs_pred_taken != rs_taken)
                mispredict = 1'b1;
            else if (rs_taken && (rs_pred_target != rs_target))
                mispredict = 1'b1;
        end
    end

    // R5: the target store only answers on a taken direction
    a_r5_gated: assert property (@(posedge clk) disable iff (rst)
        pred_tgt_vld |-> pred_taken);

    // R7: without a target hit fetch continues sequentially
    a_r7_seq: assert property (@(posedge clk) disable iff (rst)
        !pred_tgt_vld |-> next_pc == f_pc + SEQ_STEP);

    // R9: no resolve, no mispredict
    a_r9_quiet: assert property (@(posedge clk) disable iff (rst)
        !rs_valid |-> !mispredict);

endmodule

// File: tb/dir_tgt_predictor_test.sv
module dir_tgt_predictor_test;
    localparam int CLK_PERIOD = 10;
    localparam int NV = 20;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] f_pc = '0;
    logic        pred_taken, pred_tgt_vld, mispredict;
    logic [31:0] pred_tgt, next_pc;
    logic        rs_valid = 1'b0, rs_taken = 1'b0, rs_pred_taken = 1'b0;
    logic [31:0] rs_pc = '0, rs_target = '0, rs_pred_target = '0;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    dir_tgt_predictor #(.DIR_IDX_W(6), .TGT_IDX_W(2)) uut (
        .clk(clk), .rst(rst), .f_pc(f_pc),
        .pred_taken(pred_taken), .pred_tgt_vld(pred_tgt_vld),
        .pred_tgt(pred_tgt), .next_pc(next_pc),
        .rs_valid(rs_valid), .rs_pc(rs_pc), .rs_taken(rs_taken),
        .rs_target(rs_target), .rs_pred_taken(rs_pred_taken),
        .rs_pred_target(rs_pred_target), .mispredict(mispredict)
    );

    typedef struct packed {
        logic [31:0] pc;
        logic        rv;
        logic        rt;
        logic [31:0] tg;
        logic        ed;
        logic        ev;
        logic [31:0] en;
        logic [3:0]  rq;
    } vec_t;

    // A=0x104 and B=0x204 share counter 1 and target slot 1 but differ in tag.
    localparam vec_t VECS [NV] = '{
        '{32'h104, 1'b0, 1'b0, 32'h0,   1'b0, 1'b0, 32'h108, 4'd1},  // R1 fresh state
        '{32'h104, 1'b1, 1'b1, 32'h200, 1'b0, 1'b0, 32'h108, 4'd8},  // R8 old value seen during fill
        '{32'h104, 1'b0, 1'b0, 32'h0,   1'b1, 1'b1, 32'h200, 4'd7},  // R7 redirect
        '{32'h104, 1'b1, 1'b1, 32'h200, 1'b1, 1'b1, 32'h200, 4'd2},  // R2 to 11
        '{32'h104, 1'b1, 1'b0, 32'h0,   1'b1, 1'b1, 32'h200, 4'd6},  // R6 NT resolve
        '{32'h104, 1'b0, 1'b0, 32'h0,   1'b1, 1'b1, 32'h200, 4'd3},  // R3 still taken
        '{32'h104, 1'b1, 1'b0, 32'h0,   1'b1, 1'b1, 32'h200, 4'd3},  // R3 second NT
        '{32'h104, 1'b0, 1'b0, 32'h0,   1'b0, 1'b0, 32'h108, 4'd5},  // R5 entry valid but gated
        '{32'h104, 1'b1, 1'b0, 32'h0,   1'b0, 1'b0, 32'h108, 4'd2},  // R2 to 00
        '{32'h104, 1'b1, 1'b0, 32'h0,   1'b0, 1'b0, 32'h108, 4'd2},  // R2 saturate low
        '{32'h104, 1'b1, 1'b1, 32'h300, 1'b0, 1'b0, 32'h108, 4'd2},  // R2 00 to 01
        '{32'h104, 1'b0, 1'b1, 32'h500, 1'b0, 1'b0, 32'h108, 4'd2},  // R2 still NT
        '{32'h104, 1'b0, 1'b0, 32'h0,   1'b0, 1'b0, 32'h108, 4'd10}, // R10 invalid resolve ignored
        '{32'h104, 1'b1, 1'b1, 32'h300, 1'b0, 1'b0, 32'h108, 4'd2},  // R2 to 10
        '{32'h104, 1'b0, 1'b0, 32'h0,   1'b1, 1'b1, 32'h300, 4'd6},  // R6 replaced target
        '{32'h104, 1'b1, 1'b1, 32'h600, 1'b1, 1'b1, 32'h300, 4'd8},  // R8 old target during write
        '{32'h204, 1'b0, 1'b0, 32'h0,   1'b1, 1'b0, 32'h208, 4'd4},  // R4 aliased counter, tag miss
        '{32'h204, 1'b1, 1'b1, 32'h400, 1'b1, 1'b0, 32'h208, 4'd5},  // R5 miss before fill
        '{32'h104, 1'b0, 1'b0, 32'h0,   1'b1, 1'b0, 32'h108, 4'd6},  // R6 evicted by B
        '{32'h204, 1'b0, 1'b0, 32'h0,   1'b1, 1'b1, 32'h400, 4'd7}   // R7 redirect for B
    };

    task automatic check(input bit ok, input string what, input logic [31:0] act,
                         input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", what, act, exp);
        end
    endtask

    task automatic mp_case(input logic v, input logic pt, input logic at,
                           input logic [31:0] ptg, input logic [31:0] atg,
                           input logic exp);
        @(negedge clk);
        rs_valid = v; rs_pred_taken = pt; rs_taken = at;
        rs_pred_target = ptg; rs_target = atg; rs_pc = 32'h704;
        #1;
        check(mispredict == exp, "R9 mispredict", {31'd0, mispredict}, {31'd0, exp});
        rs_valid = 1'b0;
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        errors++;
        $display("FAIL watchdog expired");
        $display("  Result: errors=%0d of %0d checks", errors, checks + 1);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            f_pc = VECS[i].pc;
            rs_pc = VECS[i].pc;
            rs_valid = VECS[i].rv;
            rs_taken = VECS[i].rt;
            rs_target = VECS[i].tg;
            #1;
            check(pred_taken == VECS[i].ed, $sformatf("R%0d step %0d pred_taken", VECS[i].rq, i),
                  {31'd0, pred_taken}, {31'd0, VECS[i].ed});
            check(pred_tgt_vld == VECS[i].ev, $sformatf("R%0d step %0d pred_tgt_vld", VECS[i].rq, i),
                  {31'd0, pred_tgt_vld}, {31'd0, VECS[i].ev});
            check(next_pc == VECS[i].en, $sformatf("R%0d step %0d next_pc", VECS[i].rq, i),
                  next_pc, VECS[i].en);
            if (VECS[i].ev)
                check(pred_tgt == VECS[i].en, $sformatf("R%0d step %0d pred_tgt", VECS[i].rq, i),
                      pred_tgt, VECS[i].en);
        end

        // R9 mispredict cases, driven without letting a resolve reach an edge
        @(negedge clk);
        rs_valid = 1'b0;
        mp_case(1'b1, 1'b0, 1'b0, 32'h0,   32'h0,   1'b0);
        mp_case(1'b1, 1'b0, 1'b1, 32'h0,   32'h900, 1'b1);
        mp_case(1'b1, 1'b1, 1'b1, 32'h900, 32'h900, 1'b0);
        mp_case(1'b1, 1'b1, 1'b1, 32'h900, 32'h904, 1'b1);
        mp_case(1'b1, 1'b1, 1'b0, 32'h900, 32'h0,   1'b1);
        mp_case(1'b0, 1'b1, 1'b0, 32'h900, 32'h0,   1'b0);

        // R1 reset clears trained state for both aliased addresses
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        f_pc = 32'h204;
        #1;
        check(pred_taken == 1'b0, "R1 pred_taken after reset", {31'd0, pred_taken}, 32'd0);
        check(pred_tgt_vld == 1'b0, "R1 pred_tgt_vld after reset", {31'd0, pred_tgt_vld}, 32'd0);
        check(next_pc == 32'h208, "R1 next_pc after reset", next_pc, 32'h208);
        // R1 one taken resolve from 01 reaches 10, proving the init value
        rs_pc = 32'h204; rs_taken = 1'b1; rs_target = 32'hA00; rs_valid = 1'b1;
        @(negedge clk);
        rs_valid = 1'b0;
        #1;
        check(pred_taken == 1'b1, "R1 init counter weakly not-taken", {31'd0, pred_taken}, 32'd1);
        check(next_pc == 32'hA00, "R1 fill after reset", next_pc, 32'hA00);

        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule